// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Model

This block is a synthesizable, clock-sampled functional model of a one-bit-wide dynamic memory. The memory receives its cell address in two halves over one shared address bus. A fast sampling clock samples the active-low row strobe, column strobe and write enable. It detects their edges and turns them into row capture, column capture, read, write and refresh behaviour. Each column strobe and write enable sample needs only one clock to take effect. The model does not check analog timing or charge retention.

The first strobe fall latches one half of the address as the row. A later strobe fall latches the other half as the column. The two halves together select one cell. If write enable is already low at the column fall, the access is an early write, and the output stays off for the whole access. Otherwise the cell's value is driven for as long as the column strobe stays low. A later fall of write enable then stores the data-in bit into the cell that is being read. The output enable shows when the pin would leave high impedance. A sticky flag reports two protocol misorderings.

With the default `AW` = 6 the array holds 4096 cells. Setting `AW` = 8 gives the full 65,536-cell part.

Top module: `mux_dram`

## Requirements
- R1: A row-strobe fall latches `addr_i` as the row half. An accepted column-strobe fall latches `addr_i` as the column half. The cell index is {row, column}. Changing `addr_i` after the column is latched does not change the cell being accessed.
- R2: A column-strobe fall is ignored if the row strobe was not already sampled low on an earlier clock. This includes a fall in the same sample as the row-strobe fall. An ignored fall writes nothing and does not enable the output.
- R3: If write enable is sampled low in the same sample as an accepted column fall, `din_i` from that sample is stored. `dout_oe_o` stays 0 until the column strobe rises.
- R4: If write enable is sampled high at an accepted column fall, `dout_oe_o` is 1 from the clock edge that sampled the fall. `dout_o` equals the addressed cell.
- R5: In the edge where the column strobe is sampled high, `dout_oe_o` returns to 0. While `dout_oe_o` is 0, `dout_o` is 0.
- R6: During a read, a write-enable fall with the column strobe still low stores `din_i` from that sample. The output stays enabled and shows the cell's new value. Write enable held low afterwards stores nothing more.
- R7: A row strobe that falls and rises while the column strobe stays high changes no cell. During that access `dout_oe_o` stays 0.
- R8: While the row strobe stays low, each accepted column fall latches a new column in the same row. Each fall starts its own read or early write.
- R9: `proto_err_o` is set by either of two events. The first is an ignored column fall (R2). The second is a change of write enable while the column strobe is low in an early-write access. Once set, `proto_err_o` stays 1 until reset.
- R10: While `rst_ni` is low, `dout_oe_o`, `dout_o` and `proto_err_o` are 0, and all strobes count as high. Cell contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Shared row/column address bus |
| din_i | input | 1 | Write data bit |
| dout_o | output | 1 | Read data bit, 0 when not driven |
| dout_oe_o | output | 1 | Output drive enable, 0 models high impedance |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
A stale row or column latch shows up as wrong data on the next read of that cell. The failure is visible one clock after the column fall. Errors in the access-mode state show at `dout_oe_o` in the very edge that samples the column fall or rise. Examples are an early write that drives the output, or a read that does not drive it. A false write caused by an ignored column fall or by a refresh is invisible until a later read of the victim cell. For that reason the bench reads cells back after those events. An edge detector that loses its previous-sample state shows at once as a spurious or missing flag on `proto_err_o`.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;
  typedef enum logic [1:0] {
    COL_IDLE = 2'd0,
    COL_READ = 2'd1,
    COL_EWR  = 2'd2,
    COL_LWR  = 2'd3
  } col_state_e;
endpackage

// File: rtl/mux_dram_edges.sv
module mux_dram_edges #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_ni,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= lvl_ni[g];
    end
    assign fall_o[g] = prev_q & ~lvl_ni[g];
    assign rise_o[g] = ~prev_q & lvl_ni[g];
  end
endmodule

// File: rtl/mux_dram_array.sv
module mux_dram_array #(
  parameter int IW = 12
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_bit_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          rd_bit_o
);
  localparam int DEPTH = 1 << IW;

  logic cells_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) cells_q[wr_idx_i] <= wr_bit_i;
  end

  assign rd_bit_o = cells_q[rd_idx_i];
endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mux_dram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ras_fall_i,
  input  logic            ras_rise_i,
  input  logic            cas_fall_i,
  input  logic            cas_rise_i,
  input  logic            we_fall_i,
  input  logic            we_chg_i,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            din_i,
  output logic            wr_en_o,
  output logic [2*AW-1:0] wr_idx_o,
  output logic            wr_bit_o,
  output logic [2*AW-1:0] rd_idx_o,
  output logic            drive_o,
  output logic            err_o
);
  logic          row_act_q;
  logic [AW-1:0] row_q, col_q;
  col_state_e    st_q;
  logic          err_q;

  logic cas_take, early_wr, late_wr, bad_cas, bad_we;

  // column fall counts only once the internal row strobe is up
  assign cas_take = cas_fall_i & row_act_q;
  assign early_wr = cas_take & ~we_ni;
  assign late_wr  = (st_q == COL_READ) & we_fall_i & ~cas_ni;
  assign bad_cas  = cas_fall_i & ~row_act_q;
  assign bad_we   = (st_q == COL_EWR) & ~cas_ni & we_chg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_act_q <= 1'b0;
      row_q     <= '0;
    end else if (ras_fall_i) begin
      row_act_q <= 1'b1;
      row_q     <= addr_i;
    end else if (ras_rise_i) begin
      row_act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      st_q  <= COL_IDLE;
    end else if (cas_take) begin
      col_q <= addr_i;
      st_q  <= we_ni ? COL_READ : COL_EWR;
    end else if (cas_rise_i) begin
      st_q  <= COL_IDLE;
    end else if (late_wr) begin
      st_q  <= COL_LWR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               err_q <= 1'b0;
    else if (bad_cas | bad_we) err_q <= 1'b1;
  end

  assign wr_en_o  = early_wr | late_wr;
  assign wr_idx_o = early_wr ? {row_q, addr_i} : {row_q, col_q};
  assign wr_bit_o = din_i;
  assign rd_idx_o = {row_q, col_q};
  assign drive_o  = (st_q == COL_READ) | (st_q == COL_LWR);
  assign err_o    = err_q;
endmodule

// File: rtl/mux_dram.sv
module mux_dram #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          dout_oe_o,
  output logic          proto_err_o
);
  localparam int IW = 2 * AW;
  localparam int NS = 3;

  logic [NS-1:0] fall, rise;
  logic          wr_en, wr_bit, rd_bit, drive;
  logic [IW-1:0] wr_idx, rd_idx;

  // bit order: 2 row, 1 column, 0 write enable
  mux_dram_edges #(.N(NS)) i_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_ni ({ras_ni, cas_ni, we_ni}),
    .fall_o (fall),
    .rise_o (rise)
  );

  mux_dram_ctrl #(.AW(AW)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_fall_i (fall[2]),
    .ras_rise_i (rise[2]),
    .cas_fall_i (fall[1]),
    .cas_rise_i (rise[1]),
    .we_fall_i  (fall[0]),
    .we_chg_i   (fall[0] | rise[0]),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .addr_i     (addr_i),
    .din_i      (din_i),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_bit_o   (wr_bit),
    .rd_idx_o   (rd_idx),
    .drive_o    (drive),
    .err_o      (proto_err_o)
  );

  mux_dram_array #(.IW(IW)) i_array (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_bit_i (wr_bit),
    .rd_idx_i (rd_idx),
    .rd_bit_o (rd_bit)
  );

  assign dout_oe_o = drive;
  assign dout_o    = drive & rd_bit;
endmodule

// File: rtl/mux_dram_chk.sv
module mux_dram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_ni,
  input logic cas_ni,
  input logic we_ni,
  input logic dout_o,
  input logic dout_oe_o,
  input logic proto_err_o
);
  p_no_drive_without_cas_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> !$past(cas_ni));

  p_release_on_cas_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_ni |=> !dout_oe_o);

  p_quiet_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_oe_o |-> !dout_o);

  p_early_write_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_ni && $past(cas_ni) && !$past(ras_ni) && !we_ni) |=> !dout_oe_o);

  p_read_drives_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_ni && $past(cas_ni) && !$past(ras_ni) && we_ni) |=> dout_oe_o);

  p_early_cas_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_ni && $past(cas_ni) && $past(ras_ni)) |=> (!dout_oe_o && proto_err_o));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
endmodule

bind mux_dram mux_dram_chk i_chk (.*);

// File: tb/test_mux_dram.sv
module test_mux_dram;
  localparam int AW = 6;
  localparam int NV = 42;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          din_i = 1'b0;
  logic          dout_o, dout_oe_o, proto_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  mux_dram #(.AW(AW)) i_mux_dram (.*);

  // {req, ras, cas, we, addr, din, exp_oe, exp_dout, exp_err}
  localparam logic [16:0] TBL [NV] = '{
    {4'd10, 3'b111, 6'd5,  4'b0000},  // R10 idle
    {4'd1,  3'b011, 6'd5,  4'b0000},  // R1 row 5
    {4'd3,  3'b010, 6'd9,  4'b1000},
    {4'd3,  3'b000, 6'd9,  4'b1000},  // R3 early write (5,9)=1
    {4'd3,  3'b000, 6'd9,  4'b0000},
    {4'd3,  3'b111, 6'd0,  4'b0000},
    {4'd10, 3'b111, 6'd0,  4'b0000},
    {4'd1,  3'b011, 6'd5,  4'b0000},
    {4'd4,  3'b001, 6'd9,  4'b0110},  // R4 read (5,9)
    {4'd1,  3'b001, 6'd63, 4'b0110},  // R1 column held
    {4'd5,  3'b011, 6'd63, 4'b0000},  // R5 release
    {4'd5,  3'b111, 6'd0,  4'b0000},
    {4'd8,  3'b010, 6'd5,  4'b0000},  // R8 page
    {4'd8,  3'b000, 6'd10, 4'b0000},
    {4'd8,  3'b010, 6'd10, 4'b0000},
    {4'd8,  3'b000, 6'd11, 4'b1000},
    {4'd8,  3'b011, 6'd11, 4'b0000},
    {4'd8,  3'b001, 6'd10, 4'b0100},
    {4'd8,  3'b011, 6'd10, 4'b0000},
    {4'd8,  3'b001, 6'd11, 4'b0110},
    {4'd8,  3'b011, 6'd11, 4'b0000},
    {4'd8,  3'b001, 6'd9,  4'b0110},
    {4'd5,  3'b111, 6'd0,  4'b0000},
    {4'd6,  3'b011, 6'd5,  4'b0000},  // R6 late write
    {4'd6,  3'b001, 6'd9,  4'b0110},
    {4'd6,  3'b000, 6'd9,  4'b0100},
    {4'd6,  3'b000, 6'd9,  4'b1100},
    {4'd6,  3'b111, 6'd0,  4'b0000},
    {4'd7,  3'b010, 6'd5,  4'b1000},  // R7 refresh
    {4'd7,  3'b110, 6'd5,  4'b1000},
    {4'd7,  3'b111, 6'd0,  4'b0000},
    {4'd7,  3'b011, 6'd5,  4'b0000},
    {4'd7,  3'b001, 6'd9,  4'b0100},
    {4'd7,  3'b011, 6'd9,  4'b0000},
    {4'd7,  3'b001, 6'd11, 4'b0110},
    {4'd7,  3'b111, 6'd0,  4'b0000},
    {4'd1,  3'b010, 6'd6,  4'b0000},  // R1 other row
    {4'd1,  3'b000, 6'd9,  4'b1000},
    {4'd1,  3'b111, 6'd0,  4'b0000},
    {4'd1,  3'b011, 6'd5,  4'b0000},
    {4'd1,  3'b001, 6'd9,  4'b0100},
    {4'd1,  3'b111, 6'd0,  4'b0000}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic drive(input logic r, input logic c, input logic w,
                       input logic [AW-1:0] a, input logic d);
    ras_ni = r; cas_ni = c; we_ni = w; addr_i = a; din_i = d;
    tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk("R10 oe in reset", dout_oe_o, 1'b0);
    chk("R10 dout in reset", dout_o, 1'b0);
    chk("R10 err in reset", proto_err_o, 1'b0);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = TBL[i];
      drive(v[12], v[11], v[10], v[9:4], v[3]);
      chk($sformatf("R%0d oe step %0d", v[16:13], i), dout_oe_o, v[2]);
      if (v[2]) chk($sformatf("R%0d dout step %0d", v[16:13], i), dout_o, v[1]);
      chk($sformatf("R%0d err step %0d", v[16:13], i), proto_err_o, v[0]);
    end

    // R2: column fall with no row active, write enable low
    drive(1'b1, 1'b1, 1'b0, 6'd9, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 6'd9, 1'b1);
    chk("R2 ignored cas oe", dout_oe_o, 1'b0);
    chk("R9 flag on ignored cas", proto_err_o, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 6'd0, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 6'd5, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 6'd9, 1'b0);
    chk("R2 no write oe", dout_oe_o, 1'b1);
    chk("R2 no write data", dout_o, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 6'd0, 1'b0);
    chk("R9 sticky", proto_err_o, 1'b1);

    // R10: reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R10 err cleared", proto_err_o, 1'b0);
    chk("R10 oe cleared", dout_oe_o, 1'b0);
    tick();
    rst_ni = 1'b1;
    tick();

    // R2: row and column fall in the same sample
    drive(1'b0, 1'b0, 1'b1, 6'd5, 1'b0);
    chk("R2 same-sample cas oe", dout_oe_o, 1'b0);
    chk("R9 flag same-sample", proto_err_o, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 6'd0, 1'b0);

    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    tick();

    // R9: write enable toggles during early write
    drive(1'b0, 1'b1, 1'b0, 6'd7, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 6'd3, 1'b1);
    chk("R9 no flag yet", proto_err_o, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 6'd3, 1'b1);
    chk("R9 flag on we change", proto_err_o, 1'b1);
    chk("R3 still off", dout_oe_o, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 6'd0, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule